// File: doc/BRIEF.md
# eMMC PHY Power-Up Sequencer

This block is a hardware sequencer that takes an eMMC I/O PHY down and back up whenever the card clock changes. It has no processor in the loop. A start request carries the new card clock in kHz. If that clock differs from the one last programmed and is above the 400 kHz identification rate, the sequencer runs a full cycle. It first drops the calibration-pad enable and then the DLL enable. It then waits for the pads to settle, enables calibration, and waits a fixed interval before it reads the calibration-done status once. If calibration passed, it programs the frequency band, enables the DLL, asserts the strobe-line read enable, and polls the DLL-ready status once per microsecond until lock or timeout.

A separate power-off request clears the calibration enable and then the DLL enable. Every operation ends with a one-cycle done pulse. Two sticky flags report a calibration timeout or a DLL timeout, and they are cleared by the next accepted request. All delays are counted in microseconds. A prescaler divides the system clock down to a microsecond tick, and this prescaler restarts at each state change.

Top module: `emmc_phy_seq`

## Requirements
- R1: After reset, `cal_en_o`, `dll_en_o`, `strobe_ren_o`, `busy_o`, `done_o`, `cal_tmo_o` and `dll_tmo_o` are low, `freq_sel_o` is 0, and the current clock is held as 0 kHz.
- R2: The band is derived from the requested clock in kHz. Below 75000 gives code 1 (50 MHz band). From 75000 up to below 125000 gives code 2 (100 MHz). From 125000 up to below 175000 gives code 3 (150 MHz). From 175000 upward gives code 0 (200 MHz).
- R3: A start request runs the full cycle only when its clock differs from the current clock and is above 400 kHz. Otherwise the sequencer pulses done in the next cycle and leaves the PHY controls untouched. Each accepted start records its clock as the current clock.
- R4: During a full cycle, `cal_en_o` rises no earlier than SETTLE_US microseconds after the start is accepted, and only after the calibration and DLL enables have been cleared.
- R5: Calibration done is sampled once, CAL_US microseconds after `cal_en_o` rises. If it is low at that moment, `cal_tmo_o` is set, done pulses, and `dll_en_o` and `strobe_ren_o` stay low.
- R6: After calibration passes, `freq_sel_o` is written first. `dll_en_o` rises in the next cycle, and `strobe_ren_o` rises in the cycle after that.
- R7: DLL ready is polled on each microsecond tick, up to DLL_TMO_US polls. If none of them sees it set, `dll_tmo_o` is set and done pulses about DLL_TMO_US microseconds after the strobe enable rose.
- R8: A power-off request clears `cal_en_o`, then clears `dll_en_o` one cycle later, then pulses done. It also resets the current clock to 0, so the next start with any clock above 400 kHz runs a full cycle.
- R9: `done_o` is high for exactly one cycle per operation, and `busy_o` is high from acceptance through the done cycle. Start or power-off requests that arrive while busy are ignored. When start and power-off arrive together in idle, power-off wins.
- R10: Both timeout flags stay set until the next accepted request, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to retune the PHY to `clk_khz_i` |
| clk_khz_i | input | CLK_W | Requested card clock in kHz |
| off_i | input | 1 | Request to power the PHY down |
| cal_done_i | input | 1 | PHY status: pad calibration complete |
| dll_rdy_i | input | 1 | PHY status: DLL locked |
| cal_en_o | output | 1 | Calibration-pad enable |
| freq_sel_o | output | 2 | DLL frequency band code |
| dll_en_o | output | 1 | DLL enable |
| strobe_ren_o | output | 1 | Strobe-line read enable |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| cal_tmo_o | output | 1 | Calibration failed at its sample point |
| dll_tmo_o | output | 1 | DLL did not lock within the poll budget |

## Verification
A wrong state transition shows up right away as a PHY control edge in the wrong order. For example, the DLL enable could rise without calibration, or the strobe enable could rise before the DLL enable. These edges are caught in the same cycle, or the cycle after, by the order checks. A miscounted delay moves the calibration enable or the done pulse by whole microseconds relative to acceptance, and the bench measures that distance in cycles. A wrong stored current clock shows at the next request: a retune that should be skipped runs instead, or a skipped one runs.

// File: rtl/emmc_phy_pkg.sv
// Package: shared types and fixed thresholds of the eMMC PHY sequencer.
// Assumes clock values are carried in kHz.
package emmc_phy_pkg;

    typedef enum logic [1:0] {
        BAND_200 = 2'd0,
        BAND_50  = 2'd1,
        BAND_100 = 2'd2,
        BAND_150 = 2'd3
    } band_t;

    localparam int unsigned EDGE_LO_KHZ  = 75000;
    localparam int unsigned EDGE_MID_KHZ = 125000;
    localparam int unsigned EDGE_HI_KHZ  = 175000;
    localparam int unsigned ID_RATE_KHZ  = 400;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OFF_CAL,
        ST_OFF_DLL,
        ST_CFG,
        ST_SETTLE,
        ST_CAL_WAIT,
        ST_FREQ,
        ST_DLL_ON,
        ST_STRB,
        ST_POLL,
        ST_PD_CAL,
        ST_PD_DLL,
        ST_DONE
    } seq_st_t;

endpackage

// File: rtl/band_sel.sv
// band_sel: maps a requested card clock (kHz) to the 2-bit DLL band code.
// Purely combinational. Assumes CLK_W is wide enough to hold 175000.
module band_sel
    import emmc_phy_pkg::*;
#(
    parameter int CLK_W = 20
) (
    input  logic [CLK_W-1:0] khz_i,
    output band_t            band_o
);
    localparam logic [CLK_W-1:0] LO_K  = CLK_W'(EDGE_LO_KHZ);
    localparam logic [CLK_W-1:0] MID_K = CLK_W'(EDGE_MID_KHZ);
    localparam logic [CLK_W-1:0] HI_K  = CLK_W'(EDGE_HI_KHZ);

    // pick the band by comparing against the three fixed edges
    always_comb begin
        if (khz_i < LO_K)       band_o = BAND_50;
        else if (khz_i < MID_K) band_o = BAND_100;
        else if (khz_i < HI_K)  band_o = BAND_150;
        else                    band_o = BAND_200;
    end
endmodule

// File: rtl/us_timer.sv
// us_timer: divides the system clock by TICK_DIV into a microsecond tick and
// counts elapsed microseconds. clr_i restarts both the prescaler and the count,
// so a wait that starts on a clear lasts whole microseconds.
module us_timer #(
    parameter int TICK_DIV = 4,
    parameter int CNT_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] us_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] presc;

    assign tick_o = (presc == LAST);

    // prescaler and microsecond counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            presc <= '0;
            us_o  <= '0;
        end else if (tick_o) begin
            presc <= '0;
            us_o  <= us_o + 1'b1;
        end else begin
            presc <= presc + 1'b1;
        end
    end

    // R4 R5 R7
    us_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !tick_o) |=> $stable(us_o));

    // R4 R5 R7
    us_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (us_o == '0));
endmodule

// File: rtl/emmc_phy_seq.sv
// emmc_phy_seq: sequences eMMC PHY power-down / calibration / DLL bring-up.
// Assumes the PHY status inputs are already synchronous to clk and that
// clk_khz_i is stable while start_i is high.
module emmc_phy_seq
    import emmc_phy_pkg::*;
#(
    parameter int CLK_W      = 20,
    parameter int TICK_DIV   = 4,
    parameter int SETTLE_US  = 3,
    parameter int CAL_US     = 500,
    parameter int DLL_TMO_US = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CLK_W-1:0] clk_khz_i,
    input  logic             off_i,
    input  logic             cal_done_i,
    input  logic             dll_rdy_i,
    output logic             cal_en_o,
    output logic [1:0]       freq_sel_o,
    output logic             dll_en_o,
    output logic             strobe_ren_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             cal_tmo_o,
    output logic             dll_tmo_o
);
    localparam int MAX_US = (CAL_US > SETTLE_US)
                          ? ((CAL_US > DLL_TMO_US) ? CAL_US : DLL_TMO_US)
                          : ((SETTLE_US > DLL_TMO_US) ? SETTLE_US : DLL_TMO_US);
    localparam int CNT_W = $clog2(MAX_US + 1) + 1;
    localparam logic [CNT_W-1:0] SETTLE_N = CNT_W'(SETTLE_US);
    localparam logic [CNT_W-1:0] CAL_N    = CNT_W'(CAL_US);
    localparam logic [CNT_W-1:0] DLL_LAST = CNT_W'(DLL_TMO_US - 1);
    localparam logic [CLK_W-1:0] ID_K     = CLK_W'(ID_RATE_KHZ);

    seq_st_t          state, state_nx;
    logic [CLK_W-1:0] cur_khz, tgt_khz;
    logic             tick;
    logic [CNT_W-1:0] us_cnt;
    band_t            band;
    logic             need_cycle, accept;

    band_sel #(.CLK_W(CLK_W)) u_band (
        .khz_i  (tgt_khz),
        .band_o (band)
    );

    us_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state != state_nx),
        .tick_o (tick),
        .us_o   (us_cnt)
    );

    assign need_cycle = (clk_khz_i != cur_khz) && (clk_khz_i > ID_K);
    assign accept     = (state == ST_IDLE) && (start_i || off_i);
    assign busy_o     = (state != ST_IDLE);
    assign done_o     = (state == ST_DONE);

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (off_i)        state_nx = ST_PD_CAL;
                else if (start_i) state_nx = need_cycle ? ST_OFF_CAL : ST_DONE;
            end
            ST_OFF_CAL:  state_nx = ST_OFF_DLL;
            ST_OFF_DLL:  state_nx = ST_CFG;
            ST_CFG:      state_nx = ST_SETTLE;
            ST_SETTLE:   if (us_cnt == SETTLE_N) state_nx = ST_CAL_WAIT;
            ST_CAL_WAIT: if (us_cnt == CAL_N)
                             state_nx = cal_done_i ? ST_FREQ : ST_DONE;
            ST_FREQ:     state_nx = ST_DLL_ON;
            ST_DLL_ON:   state_nx = ST_STRB;
            ST_STRB:     state_nx = ST_POLL;
            ST_POLL:     if (tick && (dll_rdy_i || us_cnt == DLL_LAST))
                             state_nx = ST_DONE;
            ST_PD_CAL:   state_nx = ST_PD_DLL;
            ST_PD_DLL:   state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // state register, PHY controls, flags and clock bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cur_khz      <= '0;
            tgt_khz      <= '0;
            cal_en_o     <= 1'b0;
            dll_en_o     <= 1'b0;
            strobe_ren_o <= 1'b0;
            freq_sel_o   <= 2'd0;
            cal_tmo_o    <= 1'b0;
            dll_tmo_o    <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cal_tmo_o <= 1'b0;
                dll_tmo_o <= 1'b0;
            end
            if (state == ST_IDLE && !off_i && start_i) begin
                cur_khz <= clk_khz_i;
                tgt_khz <= clk_khz_i;
            end
            case (state)
                ST_OFF_CAL, ST_PD_CAL: cal_en_o <= 1'b0;
                ST_OFF_DLL:  dll_en_o <= 1'b0;
                ST_PD_DLL: begin
                    dll_en_o <= 1'b0;
                    cur_khz  <= '0;
                end
                ST_CFG:      strobe_ren_o <= 1'b0;
                ST_SETTLE:   if (state_nx == ST_CAL_WAIT) cal_en_o <= 1'b1;
                ST_CAL_WAIT: if (us_cnt == CAL_N && !cal_done_i) cal_tmo_o <= 1'b1;
                ST_FREQ:     freq_sel_o <= band;
                ST_DLL_ON:   dll_en_o <= 1'b1;
                ST_STRB:     strobe_ren_o <= 1'b1;
                ST_POLL:     if (tick && !dll_rdy_i && us_cnt == DLL_LAST)
                                 dll_tmo_o <= 1'b1;
                default: ;
            endcase
        end
    end

    // R5
    dll_needs_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_en_o) |-> cal_en_o);

    // R5
    cal_fail_no_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_tmo_o |-> (!dll_en_o && !strobe_ren_o));

    // R6
    strobe_follows_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_en_o) |=> strobe_ren_o);

    // R6
    freq_before_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_en_o) |-> $stable(freq_sel_o));

    // R7
    dll_tmo_context_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_tmo_o) |-> (dll_en_o && strobe_ren_o && done_o));

    // R8
    off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dll_en_o) |-> !cal_en_o);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    skip_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !off_i && !need_cycle) |=> done_o);
endmodule

// File: tb/emmc_phy_seq_tb.sv
module emmc_phy_seq_tb;
    localparam int DIV = 4, SETTLE = 3, CALUS = 20, DLLUS = 10, NEVER = 1000000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, off = 1'b0;
    logic [19:0] khz = '0;
    logic cal_done, dll_rdy;
    logic cal_en, dll_en, strb, busy, done, cal_tmo, dll_tmo;
    logic [1:0] fsel;

    int errs = 0, checks = 0, cyc = 0, n_done = 0;
    int cal_lat = 30, dll_lat = 12, cal_cnt = 0, dll_cnt = 0;
    int c_cal = 0, c_cal_f = 0, c_dll = 0, c_dll_f = 0, c_str = 0, c_frq = 0;
    int t_acc = 0, t_done = 0;
    logic p_cal = 0, p_dll = 0, p_str = 0;
    logic [1:0] p_frq = 0;

    always #2 clk = ~clk;

    emmc_phy_seq #(.CLK_W(20), .TICK_DIV(DIV), .SETTLE_US(SETTLE),
                   .CAL_US(CALUS), .DLL_TMO_US(DLLUS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .clk_khz_i(khz), .off_i(off),
        .cal_done_i(cal_done), .dll_rdy_i(dll_rdy), .cal_en_o(cal_en),
        .freq_sel_o(fsel), .dll_en_o(dll_en), .strobe_ren_o(strb), .busy_o(busy),
        .done_o(done), .cal_tmo_o(cal_tmo), .dll_tmo_o(dll_tmo));

    // PHY model: status bits rise a programmable number of cycles after enable
    always @(posedge clk) begin
        cal_cnt <= cal_en ? cal_cnt + 1 : 0;
        dll_cnt <= dll_en ? dll_cnt + 1 : 0;
    end
    assign cal_done = cal_en && (cal_cnt >= cal_lat);
    assign dll_rdy  = dll_en && (dll_cnt >= dll_lat);

    // edge stamps taken away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cal_en && !p_cal) c_cal <= cyc;
        if (!cal_en && p_cal) c_cal_f <= cyc;
        if (dll_en && !p_dll) c_dll <= cyc;
        if (!dll_en && p_dll) c_dll_f <= cyc;
        if (strb && !p_str) c_str <= cyc;
        if (fsel != p_frq) c_frq <= cyc;
        if (done) n_done <= n_done + 1;
        p_cal <= cal_en; p_dll <= dll_en; p_str <= strb; p_frq <= fsel;
        if (cyc > 150000) begin
            errs++; checks++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int k = 0;
        while (!done && k < 3000) begin @(negedge clk); k++; end
        chk(done == 1'b1, "R9 done seen", int'(done), 1);
        t_done = cyc;
        @(negedge clk);
        chk(done == 1'b0, "R9 done width", int'(done), 0);
    endtask

    task automatic req_start(input int f);
        @(negedge clk);
        khz = 20'(f); start = 1'b1; t_acc = cyc;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    task automatic t_reset();
        chk({cal_en, dll_en, strb, busy, done, cal_tmo, dll_tmo} == 7'b0,
            "R1 reset outputs", int'({cal_en, dll_en, strb, busy, done, cal_tmo, dll_tmo}), 0);
        chk(fsel == 2'd0, "R1 reset band", int'(fsel), 0);
    endtask

    task automatic t_normal();
        req_start(100000);
        chk(fsel == 2'd2, "R2 100000 kHz band", int'(fsel), 2);
        chk(cal_en && dll_en && strb && !cal_tmo && !dll_tmo, "R6 all up",
            int'({cal_en, dll_en, strb, cal_tmo, dll_tmo}), 5'b11100);
        chk(c_cal - t_acc >= SETTLE * DIV, "R4 settle wait", c_cal - t_acc, SETTLE * DIV);
        chk(c_dll - c_cal >= CALUS * DIV, "R5 cal wait", c_dll - c_cal, CALUS * DIV);
        chk(c_frq == c_dll - 1, "R6 band before dll", c_frq, c_dll - 1);
        chk(c_str == c_dll + 1, "R6 strobe after dll", c_str, c_dll + 1);
    endtask

    task automatic t_band(input int f, input int exp);
        req_start(f);
        chk(int'(fsel) == exp, $sformatf("R2 band for %0d kHz", f), int'(fsel), exp);
    endtask

    task automatic t_skip(input int f);
        int fall0 = c_cal_f;
        logic [1:0] b0 = fsel;
        req_start(f);
        chk(t_done == t_acc + 1, "R3 skip done next cycle", t_done - t_acc, 1);
        chk(c_cal_f == fall0 && fsel == b0, "R3 skip leaves PHY", int'(fsel), int'(b0));
    endtask

    task automatic t_busy_ignore();
        int d0;
        @(negedge clk); khz = 20'd100000; start = 1'b1;
        @(negedge clk); start = 1'b0; d0 = n_done;
        repeat (10) @(negedge clk);
        khz = 20'd50000; start = 1'b1; off = 1'b1;
        @(negedge clk); start = 1'b0; off = 1'b0;
        wait_done();
        repeat (3) @(negedge clk);
        chk(fsel == 2'd2 && dll_en, "R9 busy request ignored", int'(fsel), 2);
        chk(n_done - d0 == 1, "R9 single done", n_done - d0, 1);
        t_skip(100000);
    endtask

    task automatic t_cal_fail();
        cal_lat = CALUS * DIV + 40;
        req_start(150000);
        chk(cal_tmo && !dll_en && !strb && !dll_tmo, "R5 cal timeout",
            int'({cal_tmo, dll_en, strb, dll_tmo}), 4'b1000);
        cal_lat = 30;
        req_start(50000);
        chk(!cal_tmo && dll_en && fsel == 2'd1, "R10 flag cleared", int'(cal_tmo), 0);
    endtask

    task automatic t_dll();
        dll_lat = NEVER;
        req_start(200000);
        chk(dll_tmo && !cal_tmo, "R7 dll timeout flag", int'(dll_tmo), 1);
        chk(t_done - c_str >= DLLUS * DIV && t_done - c_str <= DLLUS * DIV + DIV,
            "R7 dll timeout time", t_done - c_str, DLLUS * DIV);
        dll_lat = (DLLUS - 2) * DIV;
        req_start(125000);
        chk(!dll_tmo && fsel == 2'd3, "R7 late lock inside budget", int'(dll_tmo), 0);
        dll_lat = 12;
    endtask

    task automatic t_off();
        @(negedge clk); off = 1'b1;
        @(negedge clk); off = 1'b0;
        wait_done();
        chk(!cal_en && !dll_en, "R8 off clears", int'({cal_en, dll_en}), 0);
        chk(c_dll_f == c_cal_f + 1, "R8 cal then dll", c_dll_f - c_cal_f, 1);
        req_start(125000);
        chk(c_cal > t_acc && dll_en, "R8 current clock cleared", int'(dll_en), 1);
    endtask

    task automatic t_both();
        @(negedge clk); khz = 20'd60000; start = 1'b1; off = 1'b1;
        @(negedge clk); start = 1'b0; off = 1'b0;
        wait_done();
        chk(!cal_en && !dll_en, "R9 off wins", int'({cal_en, dll_en}), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_normal();
        t_band(50000, 1);   t_band(74999, 1);  t_band(75000, 2);
        t_band(124999, 2);  t_band(125000, 3); t_band(174999, 3);
        t_band(175000, 0);  t_band(200000, 0);
        t_skip(200000);
        t_skip(400);
        t_skip(300);
        t_busy_ignore();
        t_cal_fail();
        t_dll();
        t_off();
        t_both();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule